// File: doc/BRIEF.md
# Low-Power Clock Source Controller

This block picks the source for a small core's CPU clock and hands out clock enables for three clock groups: the CPU, the bus/DMA group and the peripheral group. A fourth enable, for a clock timer, runs from the slow sub clock. The whole block runs on one sampling clock. Each oscillator is seen as a one-cycle tick strobe on `fastTick` or `slowTick`. Every output enable is a registered one-cycle strobe that the clock tree would use to gate the real clock.

Firmware writes a control word through a single write strobe. The word carries the source select, two oscillator enables, a 2-bit divide field and a wake-up stabilization length. The CPU source is changed through a guarded handoff, so a pulse is never taken from both sources at once and no pulse is cut short. Three power modes are entered by command pulses and left on a wake-up pulse. Each mode gates a different set of groups. Sleep also stops the fast oscillator. Leaving sleep waits a programmed number of sub-clock ticks before the clocks restart.

Top module: `clkSrcTop`

## Requirements
- R1: After reset the CPU source is the fast oscillator, both oscillators are on, the divide ratio is 1, the block is in run mode, and the error flag is 0.
- R2: The divide field selects one CPU/bus/peripheral enable for every 1 (00), 2 (01), 4 (10) or 8 (11) ticks of the active source.
- R3: A new divide ratio takes effect only at the end of a divided period. The period in progress finishes at the old ratio.
- R4: When the source select differs from the active source, source ticks stop at once. After one more tick of the old source, the block waits for two ticks of the new source. Only then does it make the new source active, and the next new-source tick passes. `srcIsSlow` shows the active source.
- R5: A write is ignored, and `errFlag` set to 1, if it turns off the oscillator that is active or that the write selects. An accepted write clears `errFlag`.
- R6: In halt (`haltCmd`) the CPU enable stops, while the bus and peripheral enables keep running.
- R7: In deep halt (`halt2Cmd`) the CPU and bus enables stop, while the peripheral enable keeps running.
- R8: In sleep (`sleepCmd`) the fast oscillator is off and the CPU, bus and peripheral enables stop. A sleep command is ignored while the slow oscillator is off. If several commands arrive in one cycle, sleep wins over deep halt, and deep halt wins over halt.
- R9: A wake-up pulse in sleep turns the fast oscillator on. All gated enables stay off until the stabilization length (minimum 1) of slow ticks has been counted. After that the block is back in run mode.
- R10: A wake-up pulse in halt or deep halt returns the block to run mode on the next clock edge.
- R11: Writes and mode commands have no effect outside run mode.
- R12: `timerClkEn` follows every slow tick while the slow oscillator is on, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastTick | input | 1 | Fast oscillator edge strobe |
| slowTick | input | 1 | Sub-clock edge strobe |
| wrEn | input | 1 | Control word write strobe |
| wrSelSlow | input | 1 | Requested CPU source, 1 = slow |
| wrFastOn | input | 1 | Fast oscillator enable |
| wrSlowOn | input | 1 | Slow oscillator enable |
| wrDiv | input | 2 | Divide field |
| wrStab | input | STAB_W | Wake-up stabilization length in slow ticks |
| haltCmd | input | 1 | Enter halt |
| halt2Cmd | input | 1 | Enter deep halt |
| sleepCmd | input | 1 | Enter sleep |
| wakeUp | input | 1 | Wake-up event |
| cpuClkEn | output | 1 | CPU clock enable |
| busClkEn | output | 1 | Bus/DMA clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| timerClkEn | output | 1 | Clock timer enable |
| fastOscOn | output | 1 | Fast oscillator running |
| slowOscOn | output | 1 | Slow oscillator running |
| srcIsSlow | output | 1 | Active CPU source is the slow clock |
| errFlag | output | 1 | Last write was refused |

## Verification
The hardest state to reach is a refused write that lands while the block runs from the slow source with the fast oscillator stopped. Reaching it takes a full handoff, then an accepted write that stops the fast oscillator, then a write that tries to select the stopped source. The bench builds this chain with tick rates chosen so that the drain and synchronizer phases fall at known distances. The wake from sleep is reached in the same way: first a short stabilization length is written, then sleep is entered, and the wake-up pulse is timed so that the count of slow ticks decides when the enables come back. A reference model compares the outputs on every clock through all of these steps.

// File: rtl/clkSrcPkg.sv
`timescale 1ns/1ps
package clkSrcPkg;
  localparam int DIV_SEL_W = 2;
  localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;

  typedef enum logic [2:0] {
    MODE_RUN, MODE_HALT, MODE_HALT2, MODE_SLEEP, MODE_WAKE
  } pwrMode_e;

  typedef enum logic [1:0] {SW_IDLE, SW_DRAIN, SW_SYNC} swState_e;

  typedef struct packed {
    logic                 srcTick;
    logic                 slowClk;
    logic                 runCpu;
    logic                 runBus;
    logic                 runPeriph;
    logic [DIV_SEL_W-1:0] nextDiv;
  } ctrlStrobes_t;

  function automatic logic [DIV_CNT_W-1:0] divLimit(input logic [DIV_SEL_W-1:0] sel);
    logic [DIV_CNT_W-1:0] one;
    one = 1;
    return (one << sel) - 1'b1;
  endfunction
endpackage

// File: rtl/clkSrcCtrl.sv
`timescale 1ns/1ps
module clkSrcCtrl
  import clkSrcPkg::*;
#(
  parameter int STAB_W   = 8,
  parameter int STAB_RST = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fastTick,
  input  logic                 slowTick,
  input  logic                 wrEn,
  input  logic                 wrSelSlow,
  input  logic                 wrFastOn,
  input  logic                 wrSlowOn,
  input  logic [DIV_SEL_W-1:0] wrDiv,
  input  logic [STAB_W-1:0]    wrStab,
  input  logic                 haltCmd,
  input  logic                 halt2Cmd,
  input  logic                 sleepCmd,
  input  logic                 wakeUp,
  output ctrlStrobes_t         strobes,
  output logic                 fastOscOn,
  output logic                 slowOscOn,
  output logic                 srcIsSlow,
  output logic                 errFlag
);
  pwrMode_e             mode;
  swState_e             swState;
  logic                 selReq, activeSrc, syncCnt;
  logic                 fastOn, slowOn;
  logic [DIV_SEL_W-1:0] divReg;
  logic [STAB_W-1:0]    stabLen, stabCnt;
  logic                 fastClk, slowClk, oldClk, newClk, srcTick;
  logic                 inRun, reject, stabDone;

  assign fastOscOn = fastOn && (mode != MODE_SLEEP);
  assign slowOscOn = slowOn;
  assign srcIsSlow = activeSrc;
  assign fastClk   = fastTick && fastOscOn;
  assign slowClk   = slowTick && slowOn;
  assign oldClk    = activeSrc ? slowClk : fastClk;
  assign newClk    = activeSrc ? fastClk : slowClk;
  assign srcTick   = (swState == SW_IDLE) && (selReq == activeSrc) && oldClk;
  assign inRun     = (mode == MODE_RUN);
  assign reject    = (!wrFastOn && (!activeSrc || !wrSelSlow)) ||
                     (!wrSlowOn && (activeSrc || wrSelSlow));
  assign stabDone  = ({1'b0, stabCnt} + 1'b1) >= {1'b0, stabLen};

  always_comb begin
    strobes.srcTick   = srcTick;
    strobes.slowClk   = slowClk;
    strobes.runCpu    = inRun;
    strobes.runBus    = inRun || (mode == MODE_HALT);
    strobes.runPeriph = inRun || (mode == MODE_HALT) || (mode == MODE_HALT2);
    strobes.nextDiv   = divReg;
  end

  // Register write and guarded oscillator control
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReq  <= 1'b0;
      fastOn  <= 1'b1;
      slowOn  <= 1'b1;
      divReg  <= '0;
      stabLen <= STAB_W'(STAB_RST);
      errFlag <= 1'b0;
    end else begin
      if (wrEn && inRun) begin
        if (reject) errFlag <= 1'b1;
        else begin
          errFlag <= 1'b0;
          selReq  <= wrSelSlow;
          fastOn  <= wrFastOn;
          slowOn  <= wrSlowOn;
          divReg  <= wrDiv;
          stabLen <= wrStab;
        end
      end
      if (mode == MODE_SLEEP && wakeUp) fastOn <= 1'b1;
    end
  end

  // Source handoff: drain old source, then two-tick synchronizer on new one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swState   <= SW_IDLE;
      activeSrc <= 1'b0;
      syncCnt   <= 1'b0;
    end else begin
      unique case (swState)
        SW_IDLE:  if (selReq != activeSrc) swState <= SW_DRAIN;
        SW_DRAIN: if (oldClk) begin swState <= SW_SYNC; syncCnt <= 1'b0; end
        SW_SYNC:  if (newClk) begin
                    if (syncCnt) begin
                      swState   <= SW_IDLE;
                      activeSrc <= ~activeSrc;
                    end else syncCnt <= 1'b1;
                  end
        default:  swState <= SW_IDLE;
      endcase
    end
  end

  // Power mode sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_RUN;
      stabCnt <= '0;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (sleepCmd && slowOn) mode <= MODE_SLEEP;
          else if (halt2Cmd)      mode <= MODE_HALT2;
          else if (haltCmd)       mode <= MODE_HALT;
        end
        MODE_HALT, MODE_HALT2: if (wakeUp) mode <= MODE_RUN;
        MODE_SLEEP: if (wakeUp) begin mode <= MODE_WAKE; stabCnt <= '0; end
        MODE_WAKE: if (slowClk) begin
          if (stabDone) mode <= MODE_RUN;
          else stabCnt <= stabCnt + 1'b1;
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (swState == SW_IDLE && selReq == activeSrc) |=> $stable(activeSrc));
  p_refuse_keeps_osc_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($stable(fastOn) && $stable(slowOn) && $stable(selReq)));
  p_wake_fast_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_WAKE) |-> fastOscOn);
  p_halt_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_HALT || mode == MODE_HALT2) && wakeUp) |=> (mode == MODE_RUN));
endmodule

// File: rtl/clkSrcDatapath.sv
`timescale 1ns/1ps
module clkSrcDatapath
  import clkSrcPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         cpuClkEn,
  output logic         busClkEn,
  output logic         periphClkEn,
  output logic         timerClkEn
);
  logic [DIV_SEL_W-1:0] activeDiv;
  logic [DIV_CNT_W-1:0] divCnt, lim;
  logic                 divTick;

  assign lim     = divLimit(activeDiv);
  assign divTick = strobes.srcTick && (divCnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      activeDiv <= '0;
    end else if (strobes.srcTick) begin
      if (divCnt == lim) begin
        divCnt    <= '0;
        activeDiv <= strobes.nextDiv;
      end else divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuClkEn    <= 1'b0;
      busClkEn    <= 1'b0;
      periphClkEn <= 1'b0;
      timerClkEn  <= 1'b0;
    end else begin
      cpuClkEn    <= divTick && strobes.runCpu;
      busClkEn    <= divTick && strobes.runBus;
      periphClkEn <= divTick && strobes.runPeriph;
      timerClkEn  <= strobes.slowClk;
    end
  end

  p_div_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDiv) |-> (divCnt == '0));
  p_cpu_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runCpu |=> !cpuClkEn);
  p_bus_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runBus |=> !busClkEn);
  p_periph_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runPeriph |=> !periphClkEn);
endmodule

// File: rtl/clkSrcTop.sv
`timescale 1ns/1ps
module clkSrcTop
  import clkSrcPkg::*;
#(
  parameter int STAB_W   = 8,
  parameter int STAB_RST = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fastTick,
  input  logic                 slowTick,
  input  logic                 wrEn,
  input  logic                 wrSelSlow,
  input  logic                 wrFastOn,
  input  logic                 wrSlowOn,
  input  logic [1:0]           wrDiv,
  input  logic [STAB_W-1:0]    wrStab,
  input  logic                 haltCmd,
  input  logic                 halt2Cmd,
  input  logic                 sleepCmd,
  input  logic                 wakeUp,
  output logic                 cpuClkEn,
  output logic                 busClkEn,
  output logic                 periphClkEn,
  output logic                 timerClkEn,
  output logic                 fastOscOn,
  output logic                 slowOscOn,
  output logic                 srcIsSlow,
  output logic                 errFlag
);
  ctrlStrobes_t strobes;

  clkSrcCtrl #(.STAB_W(STAB_W), .STAB_RST(STAB_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick),
    .wrEn(wrEn), .wrSelSlow(wrSelSlow), .wrFastOn(wrFastOn), .wrSlowOn(wrSlowOn),
    .wrDiv(wrDiv), .wrStab(wrStab), .haltCmd(haltCmd), .halt2Cmd(halt2Cmd),
    .sleepCmd(sleepCmd), .wakeUp(wakeUp), .strobes(strobes),
    .fastOscOn(fastOscOn), .slowOscOn(slowOscOn), .srcIsSlow(srcIsSlow),
    .errFlag(errFlag)
  );

  clkSrcDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cpuClkEn(cpuClkEn), .busClkEn(busClkEn),
    .periphClkEn(periphClkEn), .timerClkEn(timerClkEn)
  );
endmodule

// File: tb/clkSrcTop_tb.sv
`timescale 1ns/1ps
module clkSrcTop_tb;
  localparam int SW = 8;
  logic clk = 0, rstN = 0;
  logic fastTick = 0, slowTick = 0, wrEn = 0, wrSelSlow = 0, wrFastOn = 1, wrSlowOn = 1;
  logic [1:0] wrDiv = 0;
  logic [SW-1:0] wrStab = 4;
  logic haltCmd = 0, halt2Cmd = 0, sleepCmd = 0, wakeUp = 0;
  logic cpuClkEn, busClkEn, periphClkEn, timerClkEn, fastOscOn, slowOscOn, srcIsSlow, errFlag;

  clkSrcTop #(.STAB_W(SW), .STAB_RST(4)) u_dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, fastPer = 2, slowPer = 9;
  string tag = "R1";
  bit done = 0;

  // Reference model state (modes: 0 run,1 halt,2 halt2,3 sleep,4 wake)
  int mMode = 0, mSw = 0, mSync = 0, mDivCnt = 0, mActDiv = 0, mDiv = 0, mStabLen = 4, mStabCnt = 0;
  bit mSel = 0, mAct = 0, mFastOn = 1, mSlowOn = 1, mErr = 0;
  bit eCpu = 0, eBus = 0, ePer = 0, eTim = 0;

  task automatic modelStep();
    bit fC, sC, oC, nC, srcT, divT, rej;
    int lim;
    fC = fastTick && mFastOn && (mMode != 3);
    sC = slowTick && mSlowOn;
    oC = mAct ? sC : fC;
    nC = mAct ? fC : sC;
    srcT = (mSw == 0) && (mSel == mAct) && oC;
    lim = (1 << mActDiv) - 1;
    divT = srcT && (mDivCnt == lim);
    eCpu = divT && mMode == 0;
    eBus = divT && (mMode == 0 || mMode == 1);
    ePer = divT && (mMode <= 2);
    eTim = sC;
    if (srcT) begin
      if (mDivCnt == lim) begin mDivCnt = 0; mActDiv = mDiv; end
      else mDivCnt++;
    end
    rej = (!wrFastOn && (!mAct || !wrSelSlow)) || (!wrSlowOn && (mAct || wrSelSlow));
    if (mSw == 0) begin if (mSel != mAct) mSw = 1; end
    else if (mSw == 1) begin if (oC) begin mSw = 2; mSync = 0; end end
    else if (nC) begin
      if (mSync == 1) begin mSw = 0; mAct = !mAct; end else mSync = 1;
    end
    if (wrEn && mMode == 0) begin
      if (rej) mErr = 1;
      else begin
        mErr = 0; mSel = wrSelSlow; mFastOn = wrFastOn; mSlowOn = wrSlowOn;
        mDiv = wrDiv; mStabLen = wrStab;
      end
    end
    case (mMode)
      0: if (sleepCmd && mSlowOn) mMode = 3; else if (halt2Cmd) mMode = 2; else if (haltCmd) mMode = 1;
      1, 2: if (wakeUp) mMode = 0;
      3: if (wakeUp) begin mMode = 4; mStabCnt = 0; mFastOn = 1; end
      default: if (sC) begin
        if (mStabCnt + 1 >= mStabLen) mMode = 0; else mStabCnt++;
      end
    endcase
  endtask

  task automatic compareAll();
    logic [7:0] act, exp;
    act = {cpuClkEn, busClkEn, periphClkEn, timerClkEn, fastOscOn, slowOscOn, srcIsSlow, errFlag};
    exp = {eCpu, eBus, ePer, eTim, mFastOn && (mMode != 3), mSlowOn, mAct, mErr};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      fastTick = (cyc % fastPer) == 0;
      slowTick = (cyc % slowPer) == 0;
      @(posedge clk);
      modelStep();
      #1;
      compareAll();
      cyc++;
      wrEn = 0; haltCmd = 0; halt2Cmd = 0; sleepCmd = 0; wakeUp = 0;
    end
  endtask

  task automatic doWrite(input bit sel, input bit fOn, input bit sOn, input logic [1:0] d, input int st);
    wrSelSlow = sel; wrFastOn = fOn; wrSlowOn = sOn; wrDiv = d; wrStab = SW'(st); wrEn = 1;
    runCycles(1);
  endtask

  task automatic checkBit(input string t, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tag = "R1";
    checkBit("R1 source fast", srcIsSlow, 0);
    checkBit("R1 fast osc on", fastOscOn, 1);
    checkBit("R1 err clear", errFlag, 0);
    runCycles(40);
    tag = "R2"; doWrite(0, 1, 1, 2'b01, 4); runCycles(40);
    tag = "R3"; doWrite(0, 1, 1, 2'b11, 4); runCycles(5);
    doWrite(0, 1, 1, 2'b10, 4); runCycles(60);
    tag = "R2"; doWrite(0, 1, 1, 2'b00, 4); runCycles(30);
    tag = "R4"; doWrite(1, 1, 1, 2'b00, 4); runCycles(80);
    checkBit("R4 slow active", srcIsSlow, 1);
    doWrite(1, 0, 1, 2'b00, 4); runCycles(10);
    tag = "R5"; doWrite(0, 0, 1, 2'b00, 4); runCycles(2);
    checkBit("R5 refused write sets err", errFlag, 1);
    checkBit("R5 fast stays off", fastOscOn, 0);
    doWrite(1, 1, 1, 2'b01, 4); runCycles(2);
    checkBit("R5 accepted write clears err", errFlag, 0);
    tag = "R4"; doWrite(0, 1, 1, 2'b01, 4); runCycles(80);
    checkBit("R4 fast active again", srcIsSlow, 0);
    tag = "R5"; doWrite(0, 0, 1, 2'b00, 4); runCycles(4);
    checkBit("R5 active osc refused", errFlag, 1);
    tag = "R6"; haltCmd = 1; runCycles(40);
    tag = "R11"; doWrite(0, 1, 1, 2'b11, 4); runCycles(5);
    tag = "R10"; wakeUp = 1; runCycles(30);
    tag = "R7"; halt2Cmd = 1; haltCmd = 1; runCycles(40);
    tag = "R10"; wakeUp = 1; runCycles(20);
    tag = "R8"; doWrite(0, 1, 0, 2'b00, 4); sleepCmd = 1; runCycles(20);
    doWrite(0, 1, 1, 2'b00, 3); runCycles(5);
    sleepCmd = 1; halt2Cmd = 1; runCycles(60);
    checkBit("R8 fast osc off in sleep", fastOscOn, 0);
    tag = "R12"; runCycles(20);
    tag = "R9"; wakeUp = 1; runCycles(1);
    checkBit("R9 fast osc back on", fastOscOn, 1);
    runCycles(60);
    tag = "R12"; slowPer = 5; fastPer = 3; runCycles(60);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule